// File: doc/BRIEF.md
# Burst-of-Two Common-Bus DDR SRAM Model

This block is a synthesizable behavioural model of a pipelined synchronous SRAM whose data moves at double data rate. Every command moves a pair of words: the command carries a word-pair index, and the model supplies the lowest word-address bit itself, 0 for the first beat and 1 for the second. Reads return data a fixed two command cycles after the command, marked by a valid flag. Writes are late writes: the data and its per-nibble write enables arrive a cycle after the command, and the array is updated later, when the next write's data comes in.

For synthesis the model runs on one clock at the beat rate, twice the command rate. After reset an internal phase alternates; the first rising edge after reset release and every second edge after it are command edges, and the edges in between carry only the second half of a beat pair. The shared data bus is presented as its pad-side split: an input, an output and an output enable that is high only while a read beat is on the bus.

A write that has not yet reached the array is held in a two-entry pending buffer, one entry per beat position. Reads merge that buffer into the array data nibble by nibble, so the read and write streams stay coherent.

Top module: `ddr_b2_sram`

## Requirements
- R1: A command is taken only on command edges (the first rising edge after reset release, then every second edge); `ld_n` low starts one, `ld_n` high is a no-operation, and `ld_n`, `rw` and `addr` on the edges in between have no effect.
- R2: Each read or write moves two words: word `2*addr` on the first beat and word `2*addr+1` on the second.
- R3: For a read taken on command edge E, the first word is on `dq_o` from fast edge E+4 (two command cycles) and the second word from edge E+5, each for one fast cycle.
- R4: `qvld` and `dq_oe` are high exactly during read beats and low otherwise; `dq_o` is all zeros whenever `dq_oe` is low.
- R5: For a write taken on command edge E, `dq_i` and `bw_n` are sampled on fast edge E+2 for the first word and on edge E+3 for the second.
- R6: `bw_n` is active low and is sampled with each beat; bit g enables data bits [4g+3:4g], so bit 0 gates bits 3:0 and bit 1 gates bits 7:4; a nibble whose enable is high keeps its previous content.
- R7: A read returns the result of every write commanded before it, including a write commanded in the immediately preceding command cycle and a chain of writes to the same pair, merged nibble by nibble, and never data of a write commanded after it.
- R8: `dq_i` and `bw_n` have no effect on any edge that is not a write-data edge of a taken write.
- R9: While `rst_n` is low and after it rises, `qvld` and `dq_oe` stay low until the first read returns data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat-rate clock, twice the command rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Active-low command strobe |
| rw | input | 1 | Command direction, 1 = read, 0 = write |
| addr | input | AW | Word-pair index |
| bw_n | input | DW/4 | Active-low nibble write enables, one per beat |
| dq_i | input | DW | Data bus, input side |
| dq_o | output | DW | Data bus, output side |
| dq_oe | output | 1 | Data bus output enable |
| qvld | output | 1 | Read data valid |

## Verification
The bench aims at the coherency corners: a read right after a write to the same pair, a read right before a write to the same pair, and two partial writes to one pair before a read. A model that read only the array would return stale nibbles in the first and third cases, and one that forwarded too eagerly would leak the later write in the second. Junk commands on the in-between edges and enabled garbage on idle data edges are driven throughout; a model that sampled on the wrong phase would raise an unexpected `qvld` or corrupt memory that a later read exposes. Every fast cycle is checked for the exact edge of each beat, so a latency off by one fast cycle, or beats in swapped order, fails at once.

// File: rtl/ddr_b2_pkg.sv
package ddr_b2_pkg;

    // Kind of operation travelling down the command pipeline
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Pipeline stage index (0 = loaded on the command edge) at which each
    // beat acts; these fix the write-data and read-data timing.
    localparam int STG_WB0    = 1;
    localparam int STG_WB1    = 2;
    localparam int STG_RB0    = 3;
    localparam int STG_RB1    = 4;
    localparam int PIPE_DEPTH = STG_RB1 + 1;

endpackage

// File: rtl/ddr_b2_slot_ctrl.sv
module ddr_b2_slot_ctrl #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_n,
    input  logic          rw,
    input  logic [AW-1:0] addr,
    output logic          slot,
    output logic          wr_go,
    output logic          wr_beat,
    output logic [AW-1:0] wr_addr,
    output logic          rd_go,
    output logic          rd_beat,
    output logic [AW-1:0] rd_addr
);
    import ddr_b2_pkg::*;

    typedef struct packed {
        logic                           phase;
        op_e [PIPE_DEPTH-1:0]           kind;
        logic [PIPE_DEPTH-1:0][AW-1:0]  adr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.phase = ~st_q.phase;
        // a command is accepted only while the phase is zero
        if (!st_q.phase && !ld_n) begin
            st_d.kind[0] = rw ? OP_READ : OP_WRITE;
        end else begin
            st_d.kind[0] = OP_IDLE;
        end
        st_d.adr[0] = addr;
        for (int k = 1; k < PIPE_DEPTH; k++) begin
            st_d.kind[k] = st_q.kind[k-1];
            st_d.adr[k]  = st_q.adr[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // ops enter only every second edge, so two neighbouring stages never
    // both hold an op; beat position follows from the stage
    always_comb begin
        slot    = ~st_q.phase;
        wr_beat = (st_q.kind[STG_WB1] == OP_WRITE);
        wr_go   = wr_beat || (st_q.kind[STG_WB0] == OP_WRITE);
        wr_addr = wr_beat ? st_q.adr[STG_WB1] : st_q.adr[STG_WB0];
        rd_beat = (st_q.kind[STG_RB1] == OP_READ);
        rd_go   = rd_beat || (st_q.kind[STG_RB0] == OP_READ);
        rd_addr = rd_beat ? st_q.adr[STG_RB1] : st_q.adr[STG_RB0];
    end

endmodule

// File: rtl/ddr_b2_wr_buf.sv
module ddr_b2_wr_buf #(
    parameter int AW = 5,
    parameter int DW = 8,
    parameter int GW = 4,
    localparam int NG = DW / GW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_go,
    input  logic                   wr_beat,
    input  logic [AW-1:0]          wr_addr,
    input  logic [NG-1:0]          bw_n,
    input  logic [DW-1:0]          dq_i,
    output logic                   cm_we,
    output logic [AW:0]            cm_word,
    output logic [DW-1:0]          cm_data,
    output logic [NG-1:0]          cm_en,
    output logic [1:0]             pend_vld,
    output logic [1:0][AW-1:0]     pend_adr,
    output logic [1:0][DW-1:0]     pend_dat,
    output logic [1:0][NG-1:0]     pend_en
);

    typedef struct packed {
        logic [1:0]             vld;
        logic [1:0][AW-1:0]     adr;
        logic [1:0][DW-1:0]     dat;
        logic [1:0][NG-1:0]     en;
    } st_t;

    st_t st_d, st_q;

    // a new beat replaces the entry of the same position; the old entry
    // is retired to the array on that same edge
    always_comb begin
        st_d = st_q;
        if (wr_go) begin
            st_d.vld[wr_beat] = 1'b1;
            st_d.adr[wr_beat] = wr_addr;
            st_d.dat[wr_beat] = dq_i;
            st_d.en[wr_beat]  = ~bw_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cm_we    = wr_go && st_q.vld[wr_beat] && (|st_q.en[wr_beat]);
        cm_word  = {st_q.adr[wr_beat], wr_beat};
        cm_data  = st_q.dat[wr_beat];
        cm_en    = st_q.en[wr_beat];
        pend_vld = st_q.vld;
        pend_adr = st_q.adr;
        pend_dat = st_q.dat;
        pend_en  = st_q.en;
    end

endmodule

// File: rtl/ddr_b2_array.sv
module ddr_b2_array #(
    parameter int AW = 5,
    parameter int DW = 8,
    parameter int GW = 4,
    localparam int NG    = DW / GW,
    localparam int WORDS = 2 ** (AW + 1)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW:0]   waddr,
    input  logic [DW-1:0] wdata,
    input  logic [NG-1:0] wen,
    input  logic [AW:0]   raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int g = 0; g < NG; g++) begin
                if (wen[g]) begin
                    mem[waddr][g*GW +: GW] <= wdata[g*GW +: GW];
                end
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/ddr_b2_rd_path.sv
module ddr_b2_rd_path #(
    parameter int AW = 5,
    parameter int DW = 8,
    parameter int GW = 4,
    localparam int NG = DW / GW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_go,
    input  logic               rd_beat,
    input  logic [AW-1:0]      rd_addr,
    input  logic [DW-1:0]      arr_q,
    input  logic [1:0]         pend_vld,
    input  logic [1:0][AW-1:0] pend_adr,
    input  logic [1:0][DW-1:0] pend_dat,
    input  logic [1:0][NG-1:0] pend_en,
    output logic [AW:0]        raddr,
    output logic [DW-1:0]      dq_o,
    output logic               dq_oe,
    output logic               qvld
);

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] dat;
    } st_t;

    st_t st_d, st_q;
    logic          hit;
    logic [DW-1:0] merged;

    assign raddr = {rd_addr, rd_beat};
    assign hit   = pend_vld[rd_beat] && (pend_adr[rd_beat] == rd_addr);

    // nibble-wise forwarding of a write that has not reached the array
    for (genvar g = 0; g < NG; g++) begin : g_merge
        assign merged[g*GW +: GW] = (hit && pend_en[rd_beat][g])
                                  ? pend_dat[rd_beat][g*GW +: GW]
                                  : arr_q[g*GW +: GW];
    end

    always_comb begin
        st_d.vld = rd_go;
        st_d.dat = rd_go ? merged : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dq_o  = st_q.dat;
    assign dq_oe = st_q.vld;
    assign qvld  = st_q.vld;

endmodule

// File: rtl/ddr_b2_sram.sv
module ddr_b2_sram #(
    parameter int AW = 5,
    parameter int DW = 8,
    parameter int GW = 4,
    localparam int NG = DW / GW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_n,
    input  logic          rw,
    input  logic [AW-1:0] addr,
    input  logic [NG-1:0] bw_n,
    input  logic [DW-1:0] dq_i,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe,
    output logic          qvld
);

    logic               slot;
    logic               wr_go, wr_beat, rd_go, rd_beat;
    logic [AW-1:0]      wr_addr, rd_addr;
    logic               cm_we;
    logic [AW:0]        cm_word, raddr;
    logic [DW-1:0]      cm_data, arr_q;
    logic [NG-1:0]      cm_en;
    logic [1:0]         pend_vld;
    logic [1:0][AW-1:0] pend_adr;
    logic [1:0][DW-1:0] pend_dat;
    logic [1:0][NG-1:0] pend_en;

    ddr_b2_slot_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
        .slot(slot), .wr_go(wr_go), .wr_beat(wr_beat), .wr_addr(wr_addr),
        .rd_go(rd_go), .rd_beat(rd_beat), .rd_addr(rd_addr)
    );

    ddr_b2_wr_buf #(.AW(AW), .DW(DW), .GW(GW)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .wr_beat(wr_beat),
        .wr_addr(wr_addr), .bw_n(bw_n), .dq_i(dq_i),
        .cm_we(cm_we), .cm_word(cm_word), .cm_data(cm_data), .cm_en(cm_en),
        .pend_vld(pend_vld), .pend_adr(pend_adr), .pend_dat(pend_dat),
        .pend_en(pend_en)
    );

    ddr_b2_array #(.AW(AW), .DW(DW), .GW(GW)) u_mem (
        .clk(clk), .we(cm_we), .waddr(cm_word), .wdata(cm_data),
        .wen(cm_en), .raddr(raddr), .rdata(arr_q)
    );

    ddr_b2_rd_path #(.AW(AW), .DW(DW), .GW(GW)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .rd_beat(rd_beat),
        .rd_addr(rd_addr), .arr_q(arr_q), .pend_vld(pend_vld),
        .pend_adr(pend_adr), .pend_dat(pend_dat), .pend_en(pend_en),
        .raddr(raddr), .dq_o(dq_o), .dq_oe(dq_oe), .qvld(qvld)
    );

endmodule

// File: rtl/ddr_b2_sram_chk.sv
module ddr_b2_sram_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ld_n,
    input logic          rw,
    input logic          slot,
    input logic          wr_go,
    input logic          wr_beat,
    input logic          qvld,
    input logic          dq_oe,
    input logic [DW-1:0] dq_o
);

    logic cmd_rd, cmd_wr;
    assign cmd_rd = slot && !ld_n && rw;
    assign cmd_wr = slot && !ld_n && !rw;

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd |-> ##5 (qvld && dq_oe) ##1 (qvld && dq_oe)); // R3

    AST_VALID_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qvld) |-> $past(cmd_rd, 5)); // R4

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_o == '0)); // R4

    AST_PAIR_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qvld) |=> qvld); // R2

    AST_WR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |-> ##2 (wr_go && !wr_beat) ##1 (wr_go && wr_beat)); // R5

endmodule

bind ddr_b2_sram ddr_b2_sram_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .slot(slot),
    .wr_go(wr_go), .wr_beat(wr_beat), .qvld(qvld), .dq_oe(dq_oe), .dq_o(dq_o)
);

// File: tb/ddr_b2_sram_test.sv
module ddr_b2_sram_test;
    localparam int AW = 5;
    localparam int DW = 8;
    localparam int GW = 4;
    localparam int NG = DW / GW;
    localparam int NPAIR = 2 ** AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_n = 1'b1;
    logic          rw = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [NG-1:0] bw_n = '1;
    logic [DW-1:0] dq_i = '0;
    logic [DW-1:0] dq_o;
    logic          dq_oe, qvld;

    always #5 clk = ~clk;

    ddr_b2_sram #(.AW(AW), .DW(DW), .GW(GW)) uut (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
        .bw_n(bw_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .qvld(qvld)
    );

    typedef struct {
        int            at;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    exp_t          sbq[$];
    logic [DW-1:0] refmem [2*NPAIR];
    int            checks = 0;
    int            errors = 0;
    int            ecnt = 0;
    bit            done = 0;

    // write data owed to the command edge that follows
    bit            pw_v = 0;
    logic [DW-1:0] pw_d0, pw_d1;
    logic [NG-1:0] pw_m0, pw_m1;

    always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic apply(input int w, input logic [DW-1:0] d, input logic [NG-1:0] m);
        for (int g = 0; g < NG; g++) begin
            if (!m[g]) refmem[w][g*GW +: GW] = d[g*GW +: GW];
        end
    endtask

    // one command cycle; called at a negedge ahead of a command edge
    task automatic slot(input bit act, input bit rd, input logic [AW-1:0] a,
                        input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                        input logic [NG-1:0] m0, input logic [NG-1:0] m1,
                        input bit junk, input string tag);
        int   e0;
        exp_t it;
        ld_n = !act;
        rw   = rd;
        addr = a;
        if (pw_v) begin dq_i = pw_d0; bw_n = pw_m0; end
        else begin dq_i = DW'($urandom); bw_n = '0; end // R8 enabled garbage
        e0 = ecnt + 1;
        if (act && rd) begin
            it.at = e0 + 4; it.data = refmem[2*a];   it.tag = tag; sbq.push_back(it);
            it.at = e0 + 5; it.data = refmem[2*a+1]; it.tag = tag; sbq.push_back(it);
        end else if (act) begin
            apply(2*a, d0, m0);
            apply(2*a + 1, d1, m1);
        end
        @(negedge clk);
        if (junk) begin // R1 command pins on the in-between edge
            ld_n = 1'b0; rw = 1'($urandom); addr = AW'($urandom);
        end else begin
            ld_n = 1'b1;
        end
        if (pw_v) begin dq_i = pw_d1; bw_n = pw_m1; end
        else begin dq_i = DW'($urandom); bw_n = '0; end
        pw_v = act && !rd;
        pw_d0 = d0; pw_d1 = d1; pw_m0 = m0; pw_m1 = m1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                      input logic [NG-1:0] m0, input logic [NG-1:0] m1);
        slot(1, 0, a, d0, d1, m0, m1, 0, "");
    endtask

    task automatic rdc(input logic [AW-1:0] a, input string tag);
        slot(1, 1, a, '0, '0, '1, '1, 0, tag);
    endtask

    task automatic nop(input bit junk);
        slot(0, 0, '0, '0, '0, '1, '1, junk, "");
    endtask

    // monitor: every fast cycle is either a scheduled beat or idle
    always @(negedge clk) begin : mon
        exp_t it;
        if (!done) begin
            if (!rst_n) begin
                chk(!qvld && !dq_oe, "R9", "quiet in reset", {6'd0, qvld, dq_oe}, '0);
            end else if (sbq.size() > 0 && sbq[0].at == ecnt) begin
                it = sbq.pop_front();
                chk(qvld && dq_oe, "R3 R4", "beat valid", {6'd0, qvld, dq_oe}, 8'h03);
                chk(dq_o === it.data, it.tag, "beat data", dq_o, it.data);
            end else begin
                // R9 also holds here: idle until the first read returns
                chk(!qvld && !dq_oe && dq_o == '0, "R1 R4", "idle bus", dq_o, '0);
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        done = 1;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : drive
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R2 R5 fill every pair back to back, then read it all back
        for (int a = 0; a < NPAIR; a++) wr(AW'(a), DW'(a*74 + 5), DW'(a*74 + 42), '0, '0);
        nop(0);
        for (int a = 0; a < NPAIR; a++) rdc(AW'(a), "R2 R5");
        nop(0);
        // R6 partial masks: keep nibble0 on beat0, nibble1 on beat1
        wr(3, 8'hA7, 8'h5C, 2'b01, 2'b10);
        nop(0);
        rdc(3, "R6");
        wr(4, 8'hFF, 8'h00, 2'b11, 2'b11);
        nop(0);
        rdc(4, "R6");
        // R7 read right after a partial write to the same pair
        wr(5, 8'h3C, 8'hC3, 2'b10, 2'b00);
        rdc(5, "R7");
        // R7 read right before a write to the same pair returns old data
        rdc(6, "R7");
        wr(6, 8'h11, 8'h22, 2'b00, 2'b00);
        rdc(6, "R7");
        // R7 two writes to one pair, then read
        wr(7, 8'h9E, 8'h4B, 2'b10, 2'b01);
        wr(7, 8'h61, 8'hD8, 2'b01, 2'b10);
        rdc(7, "R7");
        // R1 R8 junk commands on in-between edges, garbage data when idle
        for (int i = 0; i < 12; i++) nop(1);
        for (int a = 0; a < 8; a++) rdc(AW'(a), "R8");
        // mixed traffic on a few pairs
        for (int i = 0; i < 600; i++) begin
            case ($urandom % 3)
                0: nop(1'($urandom));
                1: wr(AW'($urandom % 8), DW'($urandom), DW'($urandom),
                      NG'($urandom), NG'($urandom));
                default: rdc(AW'($urandom % 8), "R7");
            endcase
        end
        for (int i = 0; i < 4; i++) nop(0);
        chk(sbq.size() == 0, "R3", "all beats returned", DW'(sbq.size()), '0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule